// File: doc/BRIEF.md
# Ratio-Coded Reference Clock Regenerator

This block rebuilds a steady timing clock, at the rate of the reference clock, from a fast core clock that a PLL produced by multiplying the reference by a programmable ratio. A 5-bit ratio code is captured while reset is held. The code value is twice the multiplication ratio, so its least significant bit is a half step. The block divides down by that code and produces a regenerated clock together with a one-tick strobe at each of its rising edges. Timers, the baud generator and bus timing logic can use that strobe as a clock enable.

All timing is modelled on a tick clock `clk` that fires once per half-period of the core clock. One regenerated period therefore lasts exactly `code` ticks: 4 ticks at 2x and 15 ticks at 7.5x. A select input chooses whether the timing output carries the raw reference clock or the regenerated clock. The reference path keeps running at full rate while the PLL locks, and the regenerated path follows the core clock. The block also produces a bus-clock enable for the bus, which runs at half the core rate. That enable fires one tick out of every four.

Top module: `ref_clk_regen`

## Requirements
- R1: `ratio_code` is sampled on every clock edge at which `rst` is high. The value sampled at the last reset edge sets the period N (in ticks) to the code value. Changes to `ratio_code` while `rst` is low have no effect on any output.
- R2: Legal codes are 4 through 15. Any other code is replaced by 4 (period of 4 ticks), and `code_err` goes high after the reset edge that samples it. `code_err` keeps its value until a later reset samples a legal code, which drives it low.
- R3: After any clock edge with `rst` high, `regen_clk`, `regen_rise` and `bus_en` are all low.
- R4: Let edge k be the k-th clock edge after `rst` falls. The regenerated clock first rises at edge N, and it rises again every N edges after that.
- R5: After each rising edge, `regen_clk` stays high for floor(N/2) ticks and low for the rest of the period. For even codes (integer ratios) this is an exact 50% duty cycle. For odd codes (half-step ratios) the high time is (N-1)/2 ticks.
- R6: `regen_rise` is high for exactly one tick, in the same tick in which `regen_clk` has just risen. It is low in every other tick.
- R7: `timing_clk` follows `ref_clk` when `src_sel` is 0 and follows `regen_clk` when `src_sel` is 1. This selection is combinational.
- R8: `bus_en` is high for one tick after edges 4, 8, 12 and so on, counted from the release of reset, and low in every other tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one edge per core half-period |
| rst | input | 1 | Synchronous active-high reset; ratio code captured while high |
| ratio_code | input | 5 | Ratio code, twice the PLL multiplication ratio |
| ref_clk | input | 1 | Raw reference clock for the bypass path |
| src_sel | input | 1 | Timing source select: 0 reference, 1 regenerated |
| regen_clk | output | 1 | Regenerated divided clock |
| regen_rise | output | 1 | One-tick strobe at each regenerated rising edge |
| timing_clk | output | 1 | Selected timing clock |
| bus_en | output | 1 | Half-core-rate bus clock enable, one tick in four |
| code_err | output | 1 | Sticky flag for a clamped out-of-range code |

## Verification
Every registered result is due one edge after the tick that causes it. `regen_clk` and `regen_rise` change at edge N and at each later multiple of N, the fall comes floor(N/2) edges after each rise, `bus_en` appears at multiples of four, and `code_err` shows its value one edge after a reset edge. The bench counts edges from the release of reset, derives each expected value from that count and the clamped code, and samples on the falling clock edge, half a tick after each result has settled. `timing_clk` has no register in its path, so the bench checks it one time unit after it changes `ref_clk` and `src_sel`. The cases cover all even and odd code families, both clamp directions, and a code change in mid-run.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int CODE_W   = 5;
    localparam int MIN_CODE = 4;
    localparam int MAX_CODE = 15;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t span;   // ticks per regenerated period
        code_t high;   // ticks spent high per period
        logic  bad;    // code was out of range and clamped
    } ratio_cfg_t;

    function automatic ratio_cfg_t decode_ratio(input code_t raw);
        ratio_cfg_t c;
        logic       ok;
        ok     = (int'(raw) >= MIN_CODE) && (int'(raw) <= MAX_CODE);
        c.span = ok ? raw : code_t'(MIN_CODE);
        c.high = c.span >> 1;
        c.bad  = !ok;
        return c;
    endfunction

endpackage

// File: rtl/rcr_ratio_latch.sv
module rcr_ratio_latch
    import rcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  code_t      raw_code,
    output ratio_cfg_t cfg
);

    // Capture while reset is held; frozen once reset drops.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= decode_ratio(raw_code);
        end
    end

endmodule

// File: rtl/rcr_phase_divider.sv
module rcr_phase_divider
    import rcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t span,
    input  code_t high,
    output logic  regen,
    output logic  rise
);

    code_t cnt;
    code_t cnt_nxt;
    logic  started;
    logic  started_nxt;
    logic  wrap;

    always_comb begin
        wrap        = (cnt == span - code_t'(1));
        cnt_nxt     = wrap ? '0 : cnt + code_t'(1);
        started_nxt = started | wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            started <= 1'b0;
            regen   <= 1'b0;
            rise    <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            started <= started_nxt;
            regen   <= started_nxt && (cnt_nxt < high);
            rise    <= wrap;
        end
    end

endmodule

// File: rtl/rcr_bus_enable.sv
module rcr_bus_enable #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic en
);

    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            en  <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + W'(1);
            en  <= (cnt == LAST);
        end
    end

endmodule

// File: rtl/ref_clk_regen.sv
module ref_clk_regen
    import rcr_pkg::*;
#(
    parameter int BUS_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              ref_clk,
    input  logic              src_sel,
    output logic              regen_clk,
    output logic              regen_rise,
    output logic              timing_clk,
    output logic              bus_en,
    output logic              code_err
);

    ratio_cfg_t cfg;

    rcr_ratio_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .raw_code (ratio_code),
        .cfg      (cfg)
    );

    rcr_phase_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .span  (cfg.span),
        .high  (cfg.high),
        .regen (regen_clk),
        .rise  (regen_rise)
    );

    rcr_bus_enable #(.DIV(BUS_DIV)) u_bus (
        .clk (clk),
        .rst (rst),
        .en  (bus_en)
    );

    assign code_err   = cfg.bad;
    assign timing_clk = src_sel ? regen_clk : ref_clk;

endmodule

// File: rtl/ref_clk_regen_chk.sv
module ref_clk_regen_chk (
    input logic clk,
    input logic rst,
    input logic regen_clk,
    input logic regen_rise,
    input logic bus_en,
    input logic code_err
);

    a_r3_reset_quiet: assert property (@(posedge clk)
        rst |=> (!regen_clk && !regen_rise && !bus_en));

    a_r6_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(regen_clk) |-> regen_rise);

    a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
        regen_rise |=> !regen_rise);

    a_r5_high_span: assert property (@(posedge clk) disable iff (rst)
        $rose(regen_clk) |=> regen_clk);

    a_r8_bus_gap: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> !bus_en);

    a_r2_err_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(code_err));

endmodule

bind ref_clk_regen ref_clk_regen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .regen_clk  (regen_clk),
    .regen_rise (regen_rise),
    .bus_en     (bus_en),
    .code_err   (code_err)
);

// File: tb/tb_ref_clk_regen.sv
`timescale 1ns/1ps
module tb_ref_clk_regen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ratio_code = 5'd4;
    logic       ref_clk = 1'b0;
    logic       src_sel = 1'b0;
    logic       regen_clk, regen_rise, timing_clk, bus_en, code_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ref_clk_regen dut (
        .clk        (clk),
        .rst        (rst),
        .ratio_code (ratio_code),
        .ref_clk    (ref_clk),
        .src_sel    (src_sel),
        .regen_clk  (regen_clk),
        .regen_rise (regen_rise),
        .timing_clk (timing_clk),
        .bus_en     (bus_en),
        .code_err   (code_err)
    );

    task automatic chk(input string req, input string what, input int tick,
                       input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at tick %0d: actual %b expected %b",
                     req, what, tick, act, exp);
        end
    endtask

    // Reference model: all results are functions of the edge count since reset release.
    task automatic run_case(input logic [4:0] code, input int len, input bit poke_code);
        int  n;
        int  h;
        bit  bad;
        int  e;
        bad = (code < 5'd4) || (code > 5'd15);
        n   = bad ? 4 : int'(code);
        h   = n / 2;
        @(negedge clk);
        rst        = 1'b1;
        ratio_code = code;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "regen_clk in reset", 0, regen_clk, 1'b0);
        chk("R3", "regen_rise in reset", 0, regen_rise, 1'b0);
        chk("R3", "bus_en in reset", 0, bus_en, 1'b0);
        chk("R2", "code_err after sample", 0, code_err, bad);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e   = 0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            if (poke_code && e == n + 1) ratio_code = ~code;   // R1: must be ignored
            ref_clk = e[1];
            src_sel = e[2];
            #1;
            chk("R4", "regen_clk rise/period", e, regen_clk,
                (e >= n) && ((e % n) < h));
            chk("R6", "regen_rise strobe", e, regen_rise,
                (e >= n) && ((e % n) == 0));
            chk("R8", "bus_en", e, bus_en, (e >= 4) && ((e % 4) == 0));
            chk("R2", "code_err sticky", e, code_err, bad);
            chk("R7", "timing_clk select", e, timing_clk,
                src_sel ? ((e >= n) && ((e % n) < h)) : ref_clk);
        end
    endtask

    // R5: direct duty measurement over one period after the first rise
    task automatic duty_case(input logic [4:0] code);
        int hi;
        @(negedge clk);
        rst        = 1'b1;
        ratio_code = code;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < int'(code); i++) @(negedge clk);
        hi = 0;
        for (int i = 0; i < int'(code); i++) begin
            if (regen_clk) hi++;
            @(negedge clk);
        end
        chk("R5", "high ticks per period", int'(code), (hi == int'(code) / 2), 1'b1);
    endtask

    initial begin
        run_case(5'd4, 20, 1'b0);
        run_case(5'd6, 24, 1'b1);   // R1 code poke
        run_case(5'd5, 22, 1'b0);
        run_case(5'd7, 25, 1'b0);
        run_case(5'd8, 30, 1'b0);
        run_case(5'd11, 36, 1'b1);
        run_case(5'd14, 45, 1'b0);
        run_case(5'd15, 48, 1'b1);
        run_case(5'd0, 16, 1'b0);   // clamp low
        run_case(5'd3, 16, 1'b0);
        run_case(5'd31, 16, 1'b1);  // clamp high
        run_case(5'd16, 16, 1'b0);
        run_case(5'd9, 30, 1'b0);   // R2 flag cleared by legal code
        duty_case(5'd6);
        duty_case(5'd12);
        duty_case(5'd9);
        duty_case(5'd15);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule